// File: doc/BRIEF.md
# Eight-Channel PWM Timer

This block is a bank of eight independent PWM timer channels behind a simple memory-mapped register port. Each channel has a 32-bit up-counter, a duty reference, a period reference and a control word. Software loads the two references, then writes the control word to start the channel. While the channel runs, the counter steps once per clock and wraps to zero at the end of each period. The channel's output pin is active low: it is driven low while the counter is below the duty reference and high for the rest of the period.

The channels sit in two address banks of four. Each channel can run continuously or stop after one period, and the counter can be cleared from software. At every period boundary the channel latches a pending flag, which raises the channel's interrupt line when interrupts are enabled for it. The control word also holds external-clock, edge-select and capture-enable bits. These bits are stored and read back, but they change nothing in the timing.

Top module: `pwm_timer_bank`

## Requirements
- R1: The address is decoded as follows. Bit 15 selects the bank, bits [5:4] select the channel inside the bank and bits [3:2] select the register (0 counter, 1 duty, 2 period, 3 control). Channels 0–3 therefore sit at 0x0000 + 0x10·n and channels 4–7 at 0x8000 + 0x10·(n−4). Duty and period hold 32 bits and read back what was written. An address with any of bits [14:6] or [1:0] set is not decoded: a write to it changes nothing and a read of it returns 0.
- R2: The control bits are: 0 run, 1 external-clock select, 2 edge select, 3 output enable, 4 one-shot, 5 interrupt enable, 6 pending, 7 counter clear, 8 capture enable. Bits 1, 2 and 8 are stored only. Bits 31:9 ignore writes and read as 0.
- R3: The counter is read-only. While run is 1 it increments on every clock and returns to 0 on the clock after it reaches P−1, where P is the period value, so one period lasts P clocks. While run is 0 the counter holds its value.
- R4: The pin is low exactly when run and output enable are both 1 and the counter is below the duty value D. If D ≥ P the pin stays low, and if D = 0 it stays high.
- R5: With output enable at 0 the pin stays high, while the counter keeps running.
- R6: Pending is set on every period wrap. The interrupt line equals pending AND interrupt enable. A control write with bit 6 = 0 clears pending. A write with bit 6 = 1 leaves pending unchanged. A wrap in the same cycle as a clearing write wins.
- R7: With one-shot set, run returns to 0 and the counter to 0 at the end of the first period, pending is set, and the pin returns high.
- R8: A control write with bit 7 = 1 clears the counter on that clock. Bit 7 reads back 1 for one cycle and then returns to 0.
- R9: Writing 0 to the control word stops the channel: the pin goes high and the counter holds.
- R10: Each channel's registers, counter, pin and interrupt are independent of the other channels.
- R11: After reset every register and counter is 0, every pin is high and every interrupt line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busSel | input | 1 | Register access strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 16 | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from the address |
| pwmPinN | output | 8 | Active-low PWM output, one per channel |
| irqOut | output | 8 | Interrupt line, one per channel |

## Verification
A register write lands on the clock edge at which it is sampled. The counter, control word, pin and interrupt show the new state right after that edge, while reads return the current state without any latency. The stimulus drives the bus on falling edges, so the edge that takes a write is the next rising edge. A wave task then queues one expected eight-pin vector per cycle, where vector j is computed from the counter value j mod P that the channel holds j clocks after the starting write. The monitor pops and compares one vector per falling edge. The counter-clear, interrupt and stop checks count whole clock edges from the starting write and read the ports back at that exact cycle.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

  // control word bit positions (software-visible layout)
  localparam int CTL_RUN     = 0;
  localparam int CTL_EXTCLK  = 1;
  localparam int CTL_EDGE    = 2;
  localparam int CTL_OE      = 3;
  localparam int CTL_ONESHOT = 4;
  localparam int CTL_IEN     = 5;
  localparam int CTL_PEND    = 6;
  localparam int CTL_CLR     = 7;
  localparam int CTL_CAPT    = 8;
  localparam int CTL_W       = 9;

  typedef enum logic [1:0] {
    REG_COUNT  = 2'd0,
    REG_DUTY   = 2'd1,
    REG_PERIOD = 2'd2,
    REG_CTRL   = 2'd3
  } regSel_e;

  // per-channel write strobes from decode to datapath
  typedef struct packed {
    logic wrDuty;
    logic wrPeriod;
    logic wrCtrl;
  } chanStrobe_t;

endpackage

// File: rtl/pwm_timer_decode.sv
module pwm_timer_decode
  import pwm_timer_pkg::*;
#(
  parameter int NUM_CHAN      = 8,
  parameter int CHAN_PER_BANK = 4,
  parameter int DATA_W        = 32,
  parameter int ADDR_W        = 16,
  parameter int BANK_BIT      = 15,
  parameter int STRIDE_LOG2   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output chanStrobe_t       strobe  [NUM_CHAN],
  input  logic [DATA_W-1:0] rdCount [NUM_CHAN],
  input  logic [DATA_W-1:0] rdDuty  [NUM_CHAN],
  input  logic [DATA_W-1:0] rdPeriod[NUM_CHAN],
  input  logic [DATA_W-1:0] rdCtrl  [NUM_CHAN],
  output logic [DATA_W-1:0] busRdata
);

  localparam int NUM_BANK   = NUM_CHAN / CHAN_PER_BANK;
  localparam int BANK_W     = (NUM_BANK > 1) ? $clog2(NUM_BANK) : 1;
  localparam int SLOT_W     = $clog2(CHAN_PER_BANK);
  localparam int CHAN_IDX_W = BANK_W + SLOT_W;
  localparam int REG_LSB    = 2;
  localparam int GAP_LSB    = STRIDE_LOG2 + SLOT_W;
  localparam int STB_W      = $bits(chanStrobe_t);

  logic [BANK_W-1:0]     bankIdx;
  logic [SLOT_W-1:0]     slotIdx;
  logic [CHAN_IDX_W-1:0] chanSel;
  regSel_e               regSel;
  logic                  addrHit;
  logic                  wrHit;
  logic [NUM_CHAN*STB_W-1:0] wrVec;

  always_comb begin
    bankIdx = busAddr[BANK_BIT +: BANK_W];
    slotIdx = busAddr[STRIDE_LOG2 +: SLOT_W];
    chanSel = {bankIdx, slotIdx};
    regSel  = regSel_e'(busAddr[REG_LSB +: 2]);
    addrHit = (busAddr[BANK_BIT-1:GAP_LSB] == '0) &&
              (busAddr[REG_LSB-1:0] == '0) &&
              (32'(bankIdx) < NUM_BANK);
    wrHit   = busSel && busWrite && addrHit;
  end

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_stb
    logic chanHit;
    assign chanHit            = wrHit && (chanSel == CHAN_IDX_W'(c));
    assign strobe[c].wrDuty   = chanHit && (regSel == REG_DUTY);
    assign strobe[c].wrPeriod = chanHit && (regSel == REG_PERIOD);
    assign strobe[c].wrCtrl   = chanHit && (regSel == REG_CTRL);
    assign wrVec[c*STB_W +: STB_W] = strobe[c];
  end

  always_comb begin
    busRdata = '0;
    if (busSel && !busWrite && addrHit) begin
      case (regSel)
        REG_COUNT:  busRdata = rdCount[chanSel];
        REG_DUTY:   busRdata = rdDuty[chanSel];
        REG_PERIOD: busRdata = rdPeriod[chanSel];
        default:    busRdata = rdCtrl[chanSel];
      endcase
    end
  end

  // R1
  single_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wrVec));

  // R1
  no_stray_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && busWrite) |-> (wrVec == '0));

endmodule

// File: rtl/pwm_timer_chan.sv
module pwm_timer_chan
  import pwm_timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  chanStrobe_t       strobe,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] countOut,
  output logic [DATA_W-1:0] dutyOut,
  output logic [DATA_W-1:0] periodOut,
  output logic [DATA_W-1:0] ctrlOut,
  output logic              pinN,
  output logic              irq
);

  logic [DATA_W-1:0] cntQ, cntD;
  logic [DATA_W-1:0] dutyQ;
  logic [DATA_W-1:0] periodQ;
  logic [CTL_W-1:0]  ctlQ, ctlD;
  logic              wrapNow;

  assign wrapNow = ctlQ[CTL_RUN] && (cntQ == periodQ - DATA_W'(1));

  always_comb begin
    ctlD          = ctlQ;
    ctlD[CTL_CLR] = 1'b0;
    if (wrapNow && ctlQ[CTL_ONESHOT]) ctlD[CTL_RUN] = 1'b0;
    if (strobe.wrCtrl) begin
      ctlD           = wdata[CTL_W-1:0];
      ctlD[CTL_PEND] = ctlQ[CTL_PEND] & wdata[CTL_PEND];
    end
    if (wrapNow) ctlD[CTL_PEND] = 1'b1;
  end

  always_comb begin
    if (strobe.wrCtrl && wdata[CTL_CLR]) cntD = '0;
    else if (ctlQ[CTL_RUN])              cntD = wrapNow ? '0 : cntQ + DATA_W'(1);
    else                                 cntD = cntQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ    <= '0;
      dutyQ   <= '0;
      periodQ <= '0;
      ctlQ    <= '0;
    end else begin
      cntQ <= cntD;
      ctlQ <= ctlD;
      if (strobe.wrDuty)   dutyQ   <= wdata;
      if (strobe.wrPeriod) periodQ <= wdata;
    end
  end

  assign countOut  = cntQ;
  assign dutyOut   = dutyQ;
  assign periodOut = periodQ;
  assign ctrlOut   = DATA_W'(ctlQ);
  assign pinN      = ~(ctlQ[CTL_RUN] & ctlQ[CTL_OE] & (cntQ < dutyQ));
  assign irq       = ctlQ[CTL_PEND] & ctlQ[CTL_IEN];

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctlQ[CTL_RUN] && !strobe.wrCtrl && !wrapNow) |=> (cntQ == $past(cntQ) + DATA_W'(1)));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctlQ[CTL_RUN] && !strobe.wrCtrl) |=> $stable(cntQ));

  // R6
  wrap_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrapNow |=> ctlQ[CTL_PEND]);

  // R7
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrapNow && ctlQ[CTL_ONESHOT] && !strobe.wrCtrl) |=> (!ctlQ[CTL_RUN] && cntQ == '0));

  // R8
  clear_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrCtrl && wdata[CTL_CLR]) |=> (cntQ == '0 && ctlQ[CTL_CLR]));

  // R5
  pin_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctlQ[CTL_OE] |-> pinN);

endmodule

// File: rtl/pwm_timer_bank.sv
module pwm_timer_bank
  import pwm_timer_pkg::*;
#(
  parameter int NUM_CHAN      = 8,
  parameter int CHAN_PER_BANK = 4,
  parameter int DATA_W        = 32,
  parameter int ADDR_W        = 16,
  parameter int BANK_BIT      = 15,
  parameter int STRIDE_LOG2   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busSel,
  input  logic                busWrite,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  output logic [NUM_CHAN-1:0] pwmPinN,
  output logic [NUM_CHAN-1:0] irqOut
);

  chanStrobe_t       strobe  [NUM_CHAN];
  logic [DATA_W-1:0] rdCount [NUM_CHAN];
  logic [DATA_W-1:0] rdDuty  [NUM_CHAN];
  logic [DATA_W-1:0] rdPeriod[NUM_CHAN];
  logic [DATA_W-1:0] rdCtrl  [NUM_CHAN];

  pwm_timer_decode #(
    .NUM_CHAN(NUM_CHAN), .CHAN_PER_BANK(CHAN_PER_BANK), .DATA_W(DATA_W),
    .ADDR_W(ADDR_W), .BANK_BIT(BANK_BIT), .STRIDE_LOG2(STRIDE_LOG2)
  ) u_decode (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .strobe(strobe), .rdCount(rdCount), .rdDuty(rdDuty),
    .rdPeriod(rdPeriod), .rdCtrl(rdCtrl), .busRdata(busRdata)
  );

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    pwm_timer_chan #(.DATA_W(DATA_W)) u_chan (
      .clk(clk), .rstN(rstN), .strobe(strobe[c]), .wdata(busWdata),
      .countOut(rdCount[c]), .dutyOut(rdDuty[c]), .periodOut(rdPeriod[c]),
      .ctrlOut(rdCtrl[c]), .pinN(pwmPinN[c]), .irq(irqOut[c])
    );
  end

endmodule

// File: tb/pwm_timer_bank_tb.sv
`timescale 1ns/1ps
module pwm_timer_bank_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [15:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [7:0]  pwmPinN;
  logic [7:0]  irqOut;

  always #2 clk = ~clk;

  pwm_timer_bank u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .pwmPinN(pwmPinN), .irqOut(irqOut)
  );

  typedef struct {
    logic [7:0] pins;
    string      tag;
  } item_t;

  item_t sbq[$];
  int    nChecks = 0;
  int    nFails  = 0;
  bit    finished = 1'b0;

  function automatic logic [15:0] chBase(int ch);
    return ((ch >= 4) ? 16'h8000 : 16'h0000) + 16'((ch % 4) * 16);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] addr, logic [31:0] data);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = addr; busWdata = data;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic rd(logic [15:0] addr, output logic [31:0] data);
    busSel = 1'b1; busWrite = 1'b0; busAddr = addr;
    #1;
    data = busRdata;
    busSel = 1'b0;
  endtask

  task automatic rdCheck(string tag, logic [15:0] addr, logic [31:0] exp);
    logic [31:0] v;
    rd(addr, v);
    check(tag, v, exp);
  endtask

  // expected pins for n cycles after the starting write: counter = j mod p
  task automatic pushWave(int ch, int p, int d, bit oe, bit oneShot, int n, string tag);
    for (int j = 0; j < n; j++) begin
      item_t it;
      it.pins = 8'hFF;
      if (oe && !(oneShot && j >= p) && ((j % p) < d)) it.pins[ch] = 1'b0;
      it.tag = tag;
      sbq.push_back(it);
    end
    while (sbq.size() != 0) @(posedge clk);
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    item_t it;
    #1;
    if (sbq.size() != 0) begin
      it = sbq.pop_front();
      nChecks++;
      if (pwmPinN !== it.pins) begin
        nFails++;
        $display("FAIL %s actual=%h expected=%h", it.tag, pwmPinN, it.pins);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] c1;
    // R11 reset state
    repeat (3) @(negedge clk);
    check("R11 pins", 32'(pwmPinN), 32'hFF);
    check("R11 irq", 32'(irqOut), 32'h0);
    rdCheck("R11 ctrl0", 16'h000C, 0);
    rdCheck("R11 period5", 16'h8018, 0);
    rstN = 1'b1;

    // R1 banks, readback, unmapped address
    wr(16'h8014, 32'hDEADBEEF);
    rdCheck("R1 duty5", 16'h8014, 32'hDEADBEEF);
    rdCheck("R1 duty1 untouched", 16'h0014, 0);
    wr(16'h0044, 32'h77);
    rdCheck("R1 gap write ignored", 16'h0004, 0);
    rdCheck("R1 gap read zero", 16'h0044, 0);

    // R2 stored-only bits, upper bits ignored
    wr(16'h801C, 32'hFFFFFF06);
    rdCheck("R2 ctrl5 readback", 16'h801C, 32'h106);
    check("R2 pins idle", 32'(pwmPinN), 32'hFF);

    // R4 R10 waveform on ch0: P=5 D=2
    wr(chBase(0) + 4, 2);
    wr(chBase(0) + 8, 5);
    wr(chBase(0) + 12, 32'h09);
    pushWave(0, 5, 2, 1'b1, 1'b0, 12, "R4 R10 ch0 wave");

    // R9 stop
    wr(chBase(0) + 12, 0);
    check("R9 pin high", 32'(pwmPinN[0]), 1);
    rd(chBase(0), c1);
    repeat (4) @(negedge clk);
    rdCheck("R9 count holds", chBase(0), c1);

    // R3 counter read-only
    wr(chBase(0), 32'h1234);
    rdCheck("R3 count write ignored", chBase(0), c1);

    // R4 duty >= period, duty 0, period 1
    wr(chBase(7) + 4, 7);
    wr(chBase(7) + 8, 3);
    wr(chBase(7) + 12, 32'h09);
    pushWave(7, 3, 7, 1'b1, 1'b0, 6, "R4 duty>=period");
    wr(chBase(7) + 12, 0);
    wr(chBase(7) + 4, 0);
    wr(chBase(7) + 8, 4);
    wr(chBase(7) + 12, 32'h09);
    pushWave(7, 4, 0, 1'b1, 1'b0, 6, "R4 duty zero");
    wr(chBase(7) + 12, 0);
    wr(chBase(6) + 4, 1);
    wr(chBase(6) + 8, 1);
    wr(chBase(6) + 12, 32'h09);
    pushWave(6, 1, 1, 1'b1, 1'b0, 5, "R4 period one");
    wr(chBase(6) + 12, 0);

    // R5 output disabled, counter runs: 5 pops then one more edge
    wr(chBase(4) + 4, 10);
    wr(chBase(4) + 8, 20);
    wr(chBase(4) + 12, 32'h01);
    pushWave(4, 20, 10, 1'b0, 1'b0, 5, "R5 oe off");
    rdCheck("R5 count runs", chBase(4), 5);
    wr(chBase(4) + 12, 0);

    // R6 pending and interrupt on ch2: P=3, wrap edge lands 3 clocks later
    wr(chBase(2) + 4, 1);
    wr(chBase(2) + 8, 3);
    wr(chBase(2) + 12, 32'h29);
    check("R6 irq before wrap", 32'(irqOut), 0);
    repeat (3) @(negedge clk);
    check("R6 irq after wrap", 32'(irqOut), 32'h04);
    wr(chBase(2) + 12, 32'h60);
    check("R6 write one keeps", 32'(irqOut), 32'h04);
    rdCheck("R6 ctrl2 kept", chBase(2) + 12, 32'h60);
    wr(chBase(2) + 12, 32'h20);
    check("R6 write zero clears", 32'(irqOut), 0);
    rdCheck("R6 ctrl2 cleared", chBase(2) + 12, 32'h20);
    wr(chBase(3) + 8, 2);
    wr(chBase(3) + 12, 32'h01);
    repeat (2) @(negedge clk);
    check("R6 no irq without enable", 32'(irqOut), 0);
    rdCheck("R6 pend without enable", chBase(3) + 12, 32'h41);
    wr(chBase(3) + 12, 0);

    // R7 one-shot on ch5: P=4 D=2
    wr(chBase(5) + 4, 2);
    wr(chBase(5) + 8, 4);
    wr(chBase(5) + 12, 32'h19);
    pushWave(5, 4, 2, 1'b1, 1'b1, 7, "R7 one-shot wave");
    rdCheck("R7 run cleared", chBase(5) + 12, 32'h58);
    rdCheck("R7 count zero", chBase(5), 0);

    // R8 counter clear on ch1
    wr(chBase(1) + 4, 500);
    wr(chBase(1) + 8, 1000);
    wr(chBase(1) + 12, 32'h09);
    repeat (20) @(negedge clk);
    wr(chBase(1) + 12, 32'h89);
    rdCheck("R8 clear bit visible", chBase(1) + 12, 32'h89);
    rdCheck("R8 count cleared", chBase(1), 0);
    @(negedge clk);
    rdCheck("R8 clear bit self-clears", chBase(1) + 12, 32'h09);
    rdCheck("R8 count restarts", chBase(1), 1);
    wr(chBase(1) + 12, 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule